// File: doc/BRIEF.md
# Three-Tap RGB Line Capture Receiver

This block sits behind a parallel line-scan color camera link. On every rising edge of the pixel clock it samples three 8-bit taps (red, green and blue of the same pixel index) together with a line qualifier and a data qualifier. A pixel is taken only when both qualifiers are high. Accepted pixels are packed into a 24-bit RGB word, tagged with their 1-based index within the line, and sent out as a valid/data stream with start-of-line and end-of-line markers.

The end of a line is seen when the line qualifier drops. For that reason every accepted pixel is held for one stage, so that the last one can leave with its end-of-line marker. When a line closes, the block latches the number of accepted pixels and compares it with a programmed expected length. That length is normally 4080, but it changes when a region of interest or a stamp is inserted into the line. A data qualifier that is high outside a line sets a sticky protocol error, which software clears.

Top module: `rgb_line_rx`

## Requirements
- R1: A pixel is accepted only on a clock edge where `lineValid` and `dataValid` are both high. A line with no such edge produces no pixel output.
- R2: `outRgb` carries red in bits [23:16], green in [15:8] and blue in [7:0], all from the same sampled cycle. `outIdx` starts at 1 and rises by one per accepted pixel.
- R3: An accepted pixel leaves on the cycle after the next accepted pixel is sampled, or on the cycle after the line end is sampled. Cycles with `lineValid` high and `dataValid` low hold it. Pixels leave in the order they arrived, with none lost or repeated.
- R4: `outSol` is high together with `outValid` on pixel 1 only.
- R5: `outEol` is high together with `outValid` on the last accepted pixel of a line. It appears in the cycle after the edge where `lineValid` is first sampled low.
- R6: `lineDone` pulses for one cycle in that same cycle, with `lineCount` holding the number of accepted pixels.
- R7: `lenErr` pulses together with `lineDone` when the count differs from `expLen`, or when the counter saturated during the line.
- R8: The pixel counter is 13 bits wide and saturates at 8191 without wrapping. `outIdx` and `lineCount` stay at 8191, and a line longer than 8191 pixels always raises `lenErr`.
- R9: `dataValid` high while `lineValid` is low accepts no pixel and sets the sticky `protoErr`. `errClear` clears it. When both happen on the same edge, setting wins.
- R10: Synchronous `rst` clears the outputs, the counter and the flags. After reset, no pixel is accepted until `lineValid` has been sampled low once.
- R11: `expLen` is used as it stands on the edge where the line end is sampled, so it can be changed between lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lineValid | input | 1 | Line qualifier |
| dataValid | input | 1 | Data qualifier |
| tapRed | input | 8 | Red tap |
| tapGreen | input | 8 | Green tap |
| tapBlue | input | 8 | Blue tap |
| expLen | input | 13 | Expected pixels per line |
| errClear | input | 1 | Clears the sticky protocol error |
| outValid | output | 1 | Output pixel valid |
| outRgb | output | 24 | Packed RGB pixel |
| outIdx | output | 13 | 1-based pixel index |
| outSol | output | 1 | Start-of-line marker |
| outEol | output | 1 | End-of-line marker |
| lineCount | output | 13 | Accepted pixels in the last closed line |
| lineDone | output | 1 | One-cycle line-closed pulse |
| lenErr | output | 1 | Length mismatch pulse |
| protoErr | output | 1 | Sticky protocol error |

## Verification
The assertions check the following on every cycle:
- the markers only ever appear on valid output cycles;
- a start marker always carries index 1;
- indices rise by exactly one until they saturate;
- the counter never wraps;
- a length error never appears without a line-closed pulse;
- the protocol error bit holds until it is cleared.

The following can only be shown by the bench's scenarios, because they need the stimulus as reference:
- which pixel data belongs to which index;
- the counts across full-length, paused, short and overlong lines;
- the effect of reprogramming the expected length;
- the refusal to lock onto a line that was already running when reset was released.

// File: rtl/rgb_rx_pkg.sv
package rgb_rx_pkg;
  // Strobes from the line control to the pixel datapath
  typedef struct packed {
    logic take;   // accept the sampled taps as a new pixel
    logic first;  // the accepted pixel is pixel 1 of the line
    logic close;  // line end sampled this edge
  } rxStrobe_t;
endpackage

// File: rtl/rx_line_ctrl.sv
module rx_line_ctrl
  import rgb_rx_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineValid,
  input  logic             dataValid,
  input  logic [CNT_W-1:0] expLen,
  input  logic             errClear,
  output rxStrobe_t        strobe,
  output logic [CNT_W-1:0] pixIdx,
  output logic [CNT_W-1:0] lineCount,
  output logic             lineDone,
  output logic             lenErr,
  output logic             protoErr
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             armed;
  logic             inLine;
  logic             satHit;
  logic [CNT_W-1:0] pixCnt;
  logic             cntFull;

  assign cntFull      = (pixCnt == CNT_MAX);
  assign pixIdx       = cntFull ? CNT_MAX : pixCnt + 1'b1;
  assign strobe.take  = armed && lineValid && dataValid;
  assign strobe.first = armed && lineValid && dataValid && (pixCnt == '0);
  assign strobe.close = armed && inLine && !lineValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      inLine    <= 1'b0;
      satHit    <= 1'b0;
      pixCnt    <= '0;
      lineCount <= '0;
      lineDone  <= 1'b0;
      lenErr    <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      lineDone <= 1'b0;
      lenErr   <= 1'b0;
      if (!armed && !lineValid) armed <= 1'b1;
      if (armed && lineValid) inLine <= 1'b1;
      if (strobe.take) begin
        pixCnt <= pixIdx;
        if (cntFull) satHit <= 1'b1;
      end
      if (strobe.close) begin
        inLine    <= 1'b0;
        pixCnt    <= '0;
        satHit    <= 1'b0;
        lineCount <= pixCnt;
        lineDone  <= 1'b1;
        lenErr    <= satHit || (pixCnt != expLen);
      end
      if (dataValid && !lineValid) protoErr <= 1'b1;
      else if (errClear)           protoErr <= 1'b0;
    end
  end

  // R8: a full counter stays full until the line closes
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cntFull && !strobe.close) |=> (pixCnt == CNT_MAX))
    else $error("counter wrapped");

  // R7: a length error only comes with a line-closed pulse
  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    lenErr |-> lineDone)
    else $error("lenErr without lineDone");

  // R9: protocol error holds until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (protoErr && !errClear) |=> protoErr)
    else $error("protoErr dropped");
endmodule

// File: rtl/rx_pixel_path.sv
module rx_pixel_path
  import rgb_rx_pkg::*;
#(
  parameter int TAP_W    = 8,
  parameter int NUM_TAPS = 3,
  parameter int CNT_W    = 13
) (
  input  logic                            clk,
  input  logic                            rst,
  input  rxStrobe_t                       strobe,
  input  logic [CNT_W-1:0]                pixIdx,
  input  logic [NUM_TAPS-1:0][TAP_W-1:0]  taps,
  output logic                            outValid,
  output logic [NUM_TAPS*TAP_W-1:0]       outRgb,
  output logic [CNT_W-1:0]                outIdx,
  output logic                            outSol,
  output logic                            outEol
);
  localparam int PIX_W = NUM_TAPS * TAP_W;
  localparam logic [CNT_W-1:0] IDX_MAX = {CNT_W{1'b1}};

  logic [PIX_W-1:0] packedPix;
  logic             pendValid;
  logic [PIX_W-1:0] pendRgb;
  logic [CNT_W-1:0] pendIdx;
  logic             pendSol;

  // Highest tap lands in the highest byte
  for (genvar g = 0; g < NUM_TAPS; g++) begin : gPack
    assign packedPix[g*TAP_W +: TAP_W] = taps[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendRgb   <= '0;
      pendIdx   <= '0;
      pendSol   <= 1'b0;
      outValid  <= 1'b0;
      outRgb    <= '0;
      outIdx    <= '0;
      outSol    <= 1'b0;
      outEol    <= 1'b0;
    end else begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outEol   <= 1'b0;
      if (strobe.take) begin
        if (pendValid) begin
          outValid <= 1'b1;
          outRgb   <= pendRgb;
          outIdx   <= pendIdx;
          outSol   <= pendSol;
        end
        pendValid <= 1'b1;
        pendRgb   <= packedPix;
        pendIdx   <= pixIdx;
        pendSol   <= strobe.first;
      end else if (strobe.close && pendValid) begin
        outValid  <= 1'b1;
        outRgb    <= pendRgb;
        outIdx    <= pendIdx;
        outSol    <= pendSol;
        outEol    <= 1'b1;
        pendValid <= 1'b0;
      end
    end
  end

  // Assertion support: index of the previous output pixel
  logic [CNT_W-1:0] prevIdx;
  always_ff @(posedge clk) begin
    if (rst)           prevIdx <= '0;
    else if (outValid) prevIdx <= outIdx;
  end

  // R4, R5: markers only on valid cycles
  a_r5_eol_valid: assert property (@(posedge clk) disable iff (rst)
    outEol |-> outValid)
    else $error("eol without valid");

  // R4: start marker carries pixel 1
  a_r4_sol_first: assert property (@(posedge clk) disable iff (rst)
    (outValid && outSol) |-> (outIdx == 1))
    else $error("sol on wrong index");

  // R2, R8: indices ascend by one until saturation
  a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outSol) |->
      ((outIdx == prevIdx + 1'b1) || (outIdx == IDX_MAX && prevIdx == IDX_MAX)))
    else $error("index not ascending");
endmodule

// File: rtl/rgb_line_rx.sv
module rgb_line_rx
  import rgb_rx_pkg::*;
#(
  parameter int TAP_W = 8,
  parameter int CNT_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lineValid,
  input  logic               dataValid,
  input  logic [TAP_W-1:0]   tapRed,
  input  logic [TAP_W-1:0]   tapGreen,
  input  logic [TAP_W-1:0]   tapBlue,
  input  logic [CNT_W-1:0]   expLen,
  input  logic               errClear,
  output logic               outValid,
  output logic [3*TAP_W-1:0] outRgb,
  output logic [CNT_W-1:0]   outIdx,
  output logic               outSol,
  output logic               outEol,
  output logic [CNT_W-1:0]   lineCount,
  output logic               lineDone,
  output logic               lenErr,
  output logic               protoErr
);
  localparam int NUM_TAPS = 3;

  rxStrobe_t                      strobe;
  logic [CNT_W-1:0]               pixIdx;
  logic [NUM_TAPS-1:0][TAP_W-1:0] tapBus;

  assign tapBus = {tapRed, tapGreen, tapBlue};

  rx_line_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst(rst), .lineValid(lineValid), .dataValid(dataValid),
    .expLen(expLen), .errClear(errClear), .strobe(strobe), .pixIdx(pixIdx),
    .lineCount(lineCount), .lineDone(lineDone), .lenErr(lenErr),
    .protoErr(protoErr)
  );

  rx_pixel_path #(.TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS), .CNT_W(CNT_W)) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .pixIdx(pixIdx), .taps(tapBus),
    .outValid(outValid), .outRgb(outRgb), .outIdx(outIdx),
    .outSol(outSol), .outEol(outEol)
  );
endmodule

// File: tb/tb_rgb_line_rx.sv
module tb_rgb_line_rx;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 8191;

  logic clk = 0;
  logic rst = 1;
  logic lineValid = 0, dataValid = 0, errClear = 0;
  logic [7:0] tapRed = 0, tapGreen = 0, tapBlue = 0;
  logic [12:0] expLen = 13'd4080;
  logic outValid, outSol, outEol, lineDone, lenErr, protoErr;
  logic [23:0] outRgb;
  logic [12:0] outIdx, lineCount;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] seed = 8'h11;

  // collector statistics
  int nOut, eolCnt, eolAt, doneCnt, gotCount, badIdx, badData, badMark, seq;
  bit gotErr;

  rgb_line_rx dut (
    .clk(clk), .rst(rst), .lineValid(lineValid), .dataValid(dataValid),
    .tapRed(tapRed), .tapGreen(tapGreen), .tapBlue(tapBlue), .expLen(expLen),
    .errClear(errClear), .outValid(outValid), .outRgb(outRgb), .outIdx(outIdx),
    .outSol(outSol), .outEol(outEol), .lineCount(lineCount),
    .lineDone(lineDone), .lenErr(lenErr), .protoErr(protoErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] expRgb(int n, logic [7:0] s);
    logic [12:0] v;
    v = n[12:0];
    return {v[7:0] ^ s, v[12:5] + s, ~v[7:0]};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    nOut = 0; eolCnt = 0; eolAt = 0; doneCnt = 0; gotCount = -1;
    badIdx = 0; badData = 0; badMark = 0; gotErr = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (outValid) begin
        seq = nOut + 1;
        if ((nOut == 0) != outSol) badMark++;
        if (int'(outIdx) != ((seq > MAXC) ? MAXC : seq)) badIdx++;
        if (outRgb != expRgb(seq, seed)) badData++;
        if (outEol) begin eolCnt++; eolAt = seq; end
        nOut++;
      end else if (outSol || outEol) badMark++;
      if (lineDone) begin
        doneCnt++; gotCount = int'(lineCount); gotErr = lenErr;
        if (nOut > 0 && !outEol) badMark++;   // R6: done aligns with eol
      end
      if (lenErr && !lineDone) badMark++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lineValid = 0; dataValid = 0;
    end
  endtask

  task automatic drivePix(int n);
    logic [23:0] w;
    w = expRgb(n, seed);
    {tapRed, tapGreen, tapBlue} = w;
  endtask

  // Drives one line of n pixels with a pause every gapEvery cycles
  task automatic sendLine(int n, int gapEvery);
    int idx = 1;
    int c = 0;
    while (idx <= n) begin
      @(negedge clk);
      lineValid = 1;
      if (gapEvery > 0 && (c % gapEvery) == gapEvery - 1) begin
        dataValid = 0; tapRed = 8'hEE;
      end else begin
        dataValid = 1; drivePix(idx); idx++;
      end
      c++;
    end
  endtask

  task automatic lineScenario(int n, int gapEvery, int expL, bit expErr, string tag);
    clearStats();
    seed = seed + 8'h27;
    expLen = expL[12:0];
    idle(2);
    sendLine(n, gapEvery);
    idle(4);
    #1;
    check(nOut == n, {tag, " R1/R3 pixel count out"}, nOut, n);
    check(badIdx == 0 && badData == 0, {tag, " R2 data/index"}, badIdx + badData, 0);
    check(badMark == 0, {tag, " R4/R6 markers"}, badMark, 0);
    check(eolCnt == 1 && eolAt == n, {tag, " R5 eol on last"}, eolAt, n);
    check(doneCnt == 1, {tag, " R6 one done pulse"}, doneCnt, 1);
    check(gotCount == ((n > MAXC) ? MAXC : n), {tag, " R6/R8 lineCount"}, gotCount,
          (n > MAXC) ? MAXC : n);
    check(gotErr == expErr, {tag, " R7/R11 lenErr"}, int'(gotErr), int'(expErr));
  endtask

  task automatic resetScenario();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; #1;
    check(!outValid && !outSol && !outEol, "R10 outputs after reset", int'(outValid), 0);
    check(lineCount == 0 && !lineDone && !lenErr, "R10 line state after reset",
          int'(lineCount), 0);
    check(!protoErr, "R10 protoErr after reset", int'(protoErr), 0);
  endtask

  task automatic emptyLine();
    clearStats();
    expLen = 13'd4080;
    idle(2);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); lineValid = 1; dataValid = 0;
    end
    idle(4); #1;
    check(nOut == 0, "R1 empty line no output", nOut, 0);
    check(doneCnt == 1 && gotCount == 0, "R1 empty line count", gotCount, 0);
    check(gotErr == 1, "R7 empty line lenErr", int'(gotErr), 1);
  endtask

  task automatic protoScenario();
    clearStats();
    idle(2);
    @(negedge clk); lineValid = 0; dataValid = 1; drivePix(1);
    @(negedge clk); lineValid = 0; dataValid = 1;
    idle(3); #1;
    check(protoErr == 1, "R9 protoErr set", int'(protoErr), 1);
    check(nOut == 0 && doneCnt == 0, "R9 nothing accepted", nOut, 0);
    lineScenario(20, 0, 20, 0, "R9 line after");
    check(protoErr == 1, "R9 sticky across line", int'(protoErr), 1);
    @(negedge clk); errClear = 1;
    @(negedge clk); errClear = 0; #1;
    check(protoErr == 0, "R9 cleared", int'(protoErr), 0);
    @(negedge clk); errClear = 1; dataValid = 1; lineValid = 0;
    @(negedge clk); errClear = 0; dataValid = 0; #1;
    check(protoErr == 1, "R9 set wins over clear", int'(protoErr), 1);
    @(negedge clk); errClear = 1;
    @(negedge clk); errClear = 0;
  endtask

  task automatic midLineReset();
    clearStats();
    idle(2);
    sendLine(20, 0);
    @(negedge clk); rst = 1; lineValid = 1; dataValid = 1;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; clearStats();
    sendLine(30, 0);
    @(negedge clk); lineValid = 1; dataValid = 0; #1;
    check(nOut == 0, "R10 no capture of running line", nOut, 0);
    idle(4); #1;
    check(nOut == 0 && doneCnt == 0, "R10 no close of running line", doneCnt, 0);
    lineScenario(40, 0, 40, 0, "R10 line after arm");
  endtask

  initial begin
    clearStats();
    repeat (3) @(negedge clk);
    rst = 0;
    resetScenario();
    lineScenario(4080, 0, 4080, 0, "R2 full line");
    lineScenario(100, 7, 4080, 1, "R3 paused short line");
    lineScenario(100, 5, 100, 0, "R11 reprogrammed length");
    lineScenario(1, 0, 1, 0, "R4 single pixel");
    emptyLine();
    protoScenario();
    midLineReset();
    lineScenario(8191, 0, 8191, 0, "R8 exact max");
    lineScenario(8200, 0, 8191, 1, "R8 overlong");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule